// File: doc/BRIEF.md
# I2C General Call Command Decoder

This block sits behind an I2C slave front end and interprets the broadcast address sequence. The front end delivers byte-level events: START (or repeated START), STOP, an eight-bit byte with a valid strobe, and the end of the acknowledge clock. The decoder watches for an all-zero write address and then reads the byte that follows. The least significant bit of that byte selects between two forms. With the bit set, the upper seven bits name a hardware master, and every following byte is data from that master. With the bit clear, the byte is a software command.

Two command codes act on the device. One resets the device and then loads the programmable address bits. The other only loads the address bits. Every other even code, including the illegal zero code, is left unacknowledged, and the rest of the transfer is ignored. The decoder asks the front end to hold SDA low through an acknowledge request level. Command side effects are issued only after the acknowledge clock has ended, so the bus is already released when the reset is applied.

Top module: `gc_decoder`

## Requirements
- R1: After a START with gc_en_i high, a first byte of 0x00 raises ack_o one cycle after byte_valid_i. Any nonzero first byte leaves ack_o low.
- R2: With gc_en_i low, a first byte of 0x00 leaves ack_o low.
- R3: A second byte with bit 0 set is acknowledged. hw_addr_o takes bits 7:1 of that byte, and hw_addr_valid_o pulses for one cycle in the same cycle that ack_o rises.
- R4: A second byte of 0x06 is acknowledged. dev_rst_o pulses in the cycle after ack_done_i, and addr_load_o pulses in the following cycle.
- R5: A second byte of 0x04 is acknowledged. addr_load_o pulses in the cycle after ack_done_i, and dev_rst_o stays low.
- R6: A second byte with bit 0 clear other than 0x06 or 0x04 (0x00 included) is not acknowledged and produces no pulse. After any command byte, further bytes are not acknowledged until a STOP or START.
- R7: In hardware-master mode, every further byte is acknowledged. hw_data_valid_o pulses with the byte on hw_data_o, and hw_addr_o keeps the captured master address.
- R8: A STOP or START drops ack_o on the next cycle and aborts the sequence. A byte that arrives after a STOP with no new START is ignored, and a START between the two bytes makes the next byte a fresh first byte.
- R9: During and after reset all outputs are low, and ack_o is low in any cycle in which dev_rst_o is high.
- R10: ack_o falls in the cycle after ack_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gc_en_i | input | 1 | Enables the general call response |
| start_i | input | 1 | START or repeated START seen |
| stop_i | input | 1 | STOP seen |
| byte_valid_i | input | 1 | A received byte is on byte_i |
| byte_i | input | 8 | Received byte |
| ack_done_i | input | 1 | The acknowledge clock has ended |
| ack_o | output | 1 | Request to hold SDA low during the acknowledge clock |
| dev_rst_o | output | 1 | One-cycle device reset pulse |
| addr_load_o | output | 1 | One-cycle strobe to load the programmable address bits |
| hw_addr_valid_o | output | 1 | A hardware master address was captured |
| hw_addr_o | output | 7 | Captured hardware master address |
| hw_data_valid_o | output | 1 | A hardware master data byte is on hw_data_o |
| hw_data_o | output | 8 | Hardware master data byte |

## Verification
The bench sends every one of the 256 possible second bytes. A decoder that tests the wrong bit, or compares the command codes loosely, would acknowledge or act on undefined codes, or would miss one of the two real commands. For the reset command, the bench checks that the reset pulse and the load pulse arrive in order in two consecutive cycles. A design that fires both together, or fires them before the acknowledge clock ends, fails that check. The bench also sends all 255 nonzero first bytes and checks the disabled case, the aborts on STOP and START, and a stray byte after a STOP. A design that keeps stale state across those events would acknowledge a byte it should ignore.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [2:0] {
    GC_IDLE,
    GC_ADDR,
    GC_CMD,
    GC_HWDATA,
    GC_SKIP
  } gc_state_e;

  typedef struct packed {
    logic ack;
    logic hw;
    logic do_rst;
    logic do_load;
  } gc_cls_t;
endpackage

// File: rtl/gc_cmd_classify.sv
module gc_cmd_classify
  import gc_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  CMD_RST  = 8'h06,
  parameter logic [7:0]  CMD_LOAD = 8'h04
) (
  input  logic [BYTE_W-1:0] byte_i,
  output gc_cls_t           cls_o
);
  logic is_rst, is_load;
  assign is_rst  = (byte_i == CMD_RST);
  assign is_load = (byte_i == CMD_LOAD);

  always_comb begin
    cls_o.hw      = byte_i[0];
    cls_o.do_rst  = is_rst;
    cls_o.do_load = is_rst | is_load;
    // zero and other even codes fall through unacknowledged
    cls_o.ack     = byte_i[0] | is_rst | is_load;
  end
endmodule

// File: rtl/gc_action_seq.sv
module gc_action_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic arm_rst_i,
  input  logic arm_load_i,
  input  logic fire_i,
  input  logic abort_i,
  output logic dev_rst_o,
  output logic addr_load_o
);
  logic pend_rst_q, pend_load_q, load_next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_rst_q  <= 1'b0;
      pend_load_q <= 1'b0;
      load_next_q <= 1'b0;
      dev_rst_o   <= 1'b0;
      addr_load_o <= 1'b0;
    end else begin
      dev_rst_o   <= 1'b0;
      addr_load_o <= load_next_q;
      load_next_q <= 1'b0;
      if (abort_i) begin
        pend_rst_q  <= 1'b0;
        pend_load_q <= 1'b0;
      end else if (arm_i) begin
        pend_rst_q  <= arm_rst_i;
        pend_load_q <= arm_load_i;
      end else if (fire_i) begin
        pend_rst_q  <= 1'b0;
        pend_load_q <= 1'b0;
        if (pend_rst_q) begin
          // reset first, address load one cycle later
          dev_rst_o   <= 1'b1;
          load_next_q <= pend_load_q;
        end else begin
          addr_load_o <= pend_load_q;
        end
      end
    end
  end
endmodule

// File: rtl/gc_ack_ctrl.sv
module gc_ack_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ack_o <= 1'b0;
    else if (clr_i)  ack_o <= 1'b0;
    else if (set_i)  ack_o <= 1'b1;
  end
endmodule

// File: rtl/gc_decoder.sv
module gc_decoder
  import gc_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter logic [7:0] CMD_RST  = 8'h06,
  parameter logic [7:0] CMD_LOAD = 8'h04,
  localparam int        HADDR_W  = BYTE_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gc_en_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_valid_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               ack_done_i,
  output logic               ack_o,
  output logic               dev_rst_o,
  output logic               addr_load_o,
  output logic               hw_addr_valid_o,
  output logic [HADDR_W-1:0] hw_addr_o,
  output logic               hw_data_valid_o,
  output logic [BYTE_W-1:0]  hw_data_o
);
  gc_state_e state_q;
  gc_cls_t   cls;
  logic      evt, byte_ev, is_gc_addr, in_cmd, in_hw, ack_set;

  gc_cmd_classify #(
    .BYTE_W  (BYTE_W),
    .CMD_RST (CMD_RST),
    .CMD_LOAD(CMD_LOAD)
  ) u_cls (
    .byte_i(byte_i),
    .cls_o (cls)
  );

  assign evt        = start_i | stop_i;
  assign byte_ev    = byte_valid_i & ~evt;
  assign is_gc_addr = (byte_i == '0) & gc_en_i;
  assign in_cmd     = byte_ev & (state_q == GC_CMD);
  assign in_hw      = byte_ev & (state_q == GC_HWDATA);
  assign ack_set    = (byte_ev & (state_q == GC_ADDR) & is_gc_addr)
                    | (in_cmd & cls.ack) | in_hw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GC_IDLE;
    end else if (stop_i) begin
      state_q <= GC_IDLE;
    end else if (start_i) begin
      state_q <= GC_ADDR;
    end else if (byte_valid_i) begin
      unique case (state_q)
        GC_ADDR:   state_q <= is_gc_addr ? GC_CMD : GC_IDLE;
        GC_CMD:    state_q <= cls.hw ? GC_HWDATA : GC_SKIP;
        default:   state_q <= state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_addr_o       <= '0;
      hw_addr_valid_o <= 1'b0;
      hw_data_o       <= '0;
      hw_data_valid_o <= 1'b0;
    end else begin
      hw_addr_valid_o <= 1'b0;
      hw_data_valid_o <= 1'b0;
      if (in_cmd && cls.hw) begin
        hw_addr_o       <= byte_i[BYTE_W-1:1];
        hw_addr_valid_o <= 1'b1;
      end
      if (in_hw) begin
        hw_data_o       <= byte_i;
        hw_data_valid_o <= 1'b1;
      end
    end
  end

  gc_ack_ctrl u_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ack_set),
    .clr_i (ack_done_i | evt),
    .ack_o (ack_o)
  );

  gc_action_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (in_cmd & cls.do_load),
    .arm_rst_i  (cls.do_rst),
    .arm_load_i (cls.do_load),
    .fire_i     (ack_done_i),
    .abort_i    (evt),
    .dev_rst_o  (dev_rst_o),
    .addr_load_o(addr_load_o)
  );
endmodule

// File: rtl/gc_decoder_chk.sv
module gc_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic byte_valid_i,
  input logic ack_done_i,
  input logic ack_o,
  input logic dev_rst_o,
  input logic addr_load_o,
  input logic hw_addr_valid_o,
  input logic hw_data_valid_o
);
  // R1
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(byte_valid_i));

  // R4
  rst_then_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |=> addr_load_o);

  // R9
  bus_free_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |-> !ack_o);

  // R8
  abort_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || start_i) |=> !ack_o);

  // R10
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_i |=> !ack_o);

  // R7
  data_from_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_data_valid_o |-> ($past(byte_valid_i) && ack_o));

  // R3
  addr_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_addr_valid_o |-> ack_o);

  // R5
  pulses_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_rst_o, addr_load_o}));
endmodule

bind gc_decoder gc_decoder_chk u_gc_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .stop_i         (stop_i),
  .byte_valid_i   (byte_valid_i),
  .ack_done_i     (ack_done_i),
  .ack_o          (ack_o),
  .dev_rst_o      (dev_rst_o),
  .addr_load_o    (addr_load_o),
  .hw_addr_valid_o(hw_addr_valid_o),
  .hw_data_valid_o(hw_data_valid_o)
);

// File: tb/sim_gc_decoder.sv
`timescale 1ns/1ps
module sim_gc_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gc_en = 1'b1;
  logic       start = 1'b0, stop = 1'b0, bvalid = 1'b0, ackd = 1'b0;
  logic [7:0] bdata = '0;
  logic       ack, drst, aload, haval, hdval;
  logic [6:0] haddr;
  logic [7:0] hdata;
  int         checks = 0, errs = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  gc_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .gc_en_i(gc_en), .start_i(start),
    .stop_i(stop), .byte_valid_i(bvalid), .byte_i(bdata), .ack_done_i(ackd),
    .ack_o(ack), .dev_rst_o(drst), .addr_load_o(aload),
    .hw_addr_valid_o(haval), .hw_addr_o(haddr),
    .hw_data_valid_o(hdval), .hw_data_o(hdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); bvalid = 1'b1; bdata = b;
    @(negedge clk); bvalid = 1'b0;
  endtask

  task automatic ack_end();
    @(negedge clk); ackd = 1'b1;
    @(negedge clk); ackd = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {ack, drst, aload, haval, hdval}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 post-reset outputs", {ack, drst, aload, haval, hdval}, 5'b0);

    // R1 every nonzero first byte ignored
    for (int a = 1; a < 256; a++) begin
      do_start(); send(8'(a));
      chk("R1 non-gc first byte", ack, 1'b0);
      do_stop();
    end

    // R2 disabled
    gc_en = 1'b0;
    do_start(); send(8'h00);
    chk("R2 disabled no ack", ack, 1'b0);
    do_stop();
    gc_en = 1'b1;

    // full sweep of second byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] v;
      logic       exp_ack;
      v = 8'(b);
      exp_ack = v[0] | (v == 8'h06) | (v == 8'h04);
      do_start(); send(8'h00);
      chk("R1 gc address ack", ack, 1'b1);
      ack_end();
      chk("R10 ack released", ack, 1'b0);
      send(v);
      chk("R6 second byte ack", ack, exp_ack);
      chk("R3 hw addr valid", haval, v[0]);
      if (v[0]) chk("R3 hw addr value", haddr, v[7:1]);
      ack_end();
      chk("R10 ack released 2", ack, 1'b0);
      chk("R4 reset pulse", drst, v == 8'h06);
      chk("R5 load pulse", aload, v == 8'h04);
      chk("R9 bus free in reset", ack & drst, 1'b0);
      @(negedge clk);
      chk("R4 reset one cycle", drst, 1'b0);
      chk("R4 load after reset", aload, v == 8'h06);
      send(8'h5A ^ v);
      chk("R7/R6 next byte ack", ack, v[0]);
      chk("R7 data valid", hdval, v[0]);
      if (v[0]) begin
        chk("R7 data value", hdata, 8'h5A ^ v);
        chk("R7 addr held", haddr, v[7:1]);
      end
      ack_end();
      chk("R6 no late pulse", {drst, aload}, 2'b0);
      do_stop();
    end

    // R8 stop aborts before ack end; stray byte ignored
    do_start(); send(8'h00);
    do_stop();
    chk("R8 stop drops ack", ack, 1'b0);
    send(8'h06);
    chk("R8 stray byte no ack", ack, 1'b0);
    ack_end(); @(negedge clk);
    chk("R8 stray byte no pulse", {drst, aload}, 2'b0);

    // R8 repeated start between bytes
    do_start(); send(8'h00); ack_end();
    do_start(); send(8'h06);
    chk("R8 restart fresh address", ack, 1'b0);
    ack_end(); @(negedge clk);
    chk("R8 restart no pulse", {drst, aload}, 2'b0);
    do_stop();

    // R8 start aborts a pending command
    do_start(); send(8'h00); ack_end(); send(8'h04);
    do_start();
    chk("R8 start drops ack", ack, 1'b0);
    ack_end();
    chk("R8 aborted command no load", aload, 1'b0);
    do_stop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule